// File: doc/BRIEF.md
# Trap-Level Banked Control Register File

This block holds the privileged control and status state of one processor core. One port reads a register by index and one port writes a register by index, both in the same cycle if needed. Most registers are stored as written. A few writes are filtered: the processor-state register keeps only its defined bits, the trap base address is aligned, and the window pointer is bounded. Some reads are built on the fly: a read-only version word, a packed translation-context word that gathers fields from several registers, and a floating-point state view with two bits forced high.

Five trap-context registers (saved PC, saved next PC, saved state, trap type and hypervisor saved state) exist once per trap level. The current trap-level register picks the copy: level L uses copy L-1. Eight scratchpad registers complete the file. Any access the file cannot honour raises a one-cycle error pulse and changes nothing.

Top module: `trap_ctl_regfile`

## Requirements
- R1: After reset every register reads zero, except the hypervisor-state register (index 0x05), which reads 0x800, and the strand-status register (index 0x06), which reads 0x50000.
- R2: A write to the processor-state register (index 0x00) stores only data bits 1 to 4, 6 to 9 and 12 (mask 0x13DE); all other bits read back as zero.
- R3: A write to the trap base register (index 0x02) stores the data with bits 14:0 cleared.
- R4: A write to the window pointer (index 0x03) with a value above NWIN (default 8) stores NWIN-1; any other value is stored unchanged.
- R5: A read of the floating-point state register (index 0x04) returns the stored value with bits 1:0 set.
- R6: The version word (index 0x07) reads NWIN in bits 7:0, MAX_TL (default 6) in bits 15:8 and MAX_GL (default 3) in bits 23:16; a write to it is refused.
- R7: The context word (index 0x08, read-only) returns hypervisor-state bit 2 at bit 0, hypervisor-state bit 5 at bit 1, processor-state bits 3:2 at bits 3:2, load/store control (index 0x0C) bits 3:2 at bits 5:4, partition (index 0x0B) bits 7:0 at bits 15:8, trap level (index 0x01, 3 bits stored) at bits 18:16, primary context (index 0x09) bits 15:0 at bits 47:32 and secondary context (index 0x0A) bits 15:0 at bits 63:48; other bits are zero. Index 0x0D is the global level.
- R8: Indices 0x10 to 0x14 (saved PC, saved next PC, saved state, trap type, hypervisor saved state) access copy L-1 where L is the trap level; copies of different levels hold independent values.
- R9: A banked access with trap level 0 or above MAX_TL is refused.
- R10: An access to an unimplemented index (0x0E, 0x0F, 0x15 to 0x17, 0x20 to 0x3F), a refused write or a refused read raises err_o in the next cycle for exactly one cycle; a refused write changes no state and a refused read returns zero.
- R11: Indices 0x18 to 0x1F are eight independent scratchpad registers.
- R12: A read in the same cycle as a write to the same index returns the old value; the new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read request |
| rd_idx | input | 6 | Read register index |
| rd_data | output | 64 | Read value, combinational, zero when refused |
| wr_en | input | 1 | Write request |
| wr_idx | input | 6 | Write register index |
| wr_data | input | 64 | Write value |
| err_o | output | 1 | One-cycle pulse, one cycle after a refused access |

## Verification
A wrong trap level or a wrong bank select shows at the ports as a saved value read back from the neighbouring level, visible on the first banked read after the level changes. A lost write filter shows as stray bits on the very next read of that register, while an error pulse that is missing, late or stretched shows in the cycle after the access. Random mixed traffic against a bench model, with trap-level writes spread over all eight codes, drives each of these paths repeatedly.

// File: rtl/trap_ctl_pkg.sv
package trap_ctl_pkg;

  localparam int DW = 64;
  localparam int IXW = 6;

  localparam logic [IXW-1:0] IX_PSTATE = 6'h00;
  localparam logic [IXW-1:0] IX_TLVL   = 6'h01;
  localparam logic [IXW-1:0] IX_TBASE  = 6'h02;
  localparam logic [IXW-1:0] IX_WINPTR = 6'h03;
  localparam logic [IXW-1:0] IX_FPST   = 6'h04;
  localparam logic [IXW-1:0] IX_HSTATE = 6'h05;
  localparam logic [IXW-1:0] IX_STRAND = 6'h06;
  localparam logic [IXW-1:0] IX_VERS   = 6'h07;
  localparam logic [IXW-1:0] IX_CTXW   = 6'h08;
  localparam logic [IXW-1:0] IX_PCTX   = 6'h09;
  localparam logic [IXW-1:0] IX_SCTX   = 6'h0A;
  localparam logic [IXW-1:0] IX_PART   = 6'h0B;
  localparam logic [IXW-1:0] IX_LSCTL  = 6'h0C;
  localparam logic [IXW-1:0] IX_GLVL   = 6'h0D;
  localparam logic [IXW-1:0] IX_PLAIN_END = 6'h0E;
  localparam logic [IXW-1:0] IX_BANK0  = 6'h10;
  localparam logic [IXW-1:0] IX_SCR0   = 6'h18;

  localparam int N_KINDS = 5;
  localparam int N_SCR   = 8;

  localparam logic [DW-1:0] PSTATE_KEEP = 64'h13DE;
  localparam logic [DW-1:0] HSTATE_RST  = 64'h800;
  localparam logic [DW-1:0] STRAND_RST  = 64'h50000;

  typedef struct packed {
    logic       bad;
    logic       bank;
    logic       scr;
    logic [2:0] sub;
  } dec_t;

  function automatic logic [DW-1:0] filt_pstate(input logic [DW-1:0] v);
    return v & PSTATE_KEEP;
  endfunction

  function automatic logic [DW-1:0] filt_tbase(input logic [DW-1:0] v);
    return {v[DW-1:15], 15'd0};
  endfunction

  function automatic logic [DW-1:0] clamp_win(input logic [DW-1:0] v, input int nwin);
    return (v > DW'(nwin)) ? DW'(nwin - 1) : v;
  endfunction

  function automatic logic [DW-1:0] fpst_view(input logic [DW-1:0] v);
    return v | 64'h3;
  endfunction

  function automatic logic [DW-1:0] vers_word(input int nwin, input int maxtl, input int maxgl);
    logic [DW-1:0] w;
    w = '0;
    w[7:0]   = 8'(nwin);
    w[15:8]  = 8'(maxtl);
    w[23:16] = 8'(maxgl);
    return w;
  endfunction

  function automatic logic [DW-1:0] pack_ctx(
    input logic [DW-1:0] hs, input logic [DW-1:0] ps, input logic [DW-1:0] ls,
    input logic [DW-1:0] part, input logic [2:0] tl,
    input logic [DW-1:0] pc, input logic [DW-1:0] sc);
    logic [DW-1:0] w;
    w = '0;
    w[0]     = hs[2];
    w[1]     = hs[5];
    w[3:2]   = ps[3:2];
    w[5:4]   = ls[3:2];
    w[15:8]  = part[7:0];
    w[18:16] = tl;
    w[47:32] = pc[15:0];
    w[63:48] = sc[15:0];
    return w;
  endfunction

endpackage

// File: rtl/trap_ctl_decode.sv
module trap_ctl_decode
  import trap_ctl_pkg::*;
#(
  parameter bit WRITE_SIDE = 1'b0,
  parameter int MAX_TL = 6,
  parameter int TL_W = 3
) (
  input  logic            en,
  input  logic [IXW-1:0]  idx,
  input  logic [TL_W-1:0] tl,
  output dec_t            dec
);

  logic tl_ok;
  logic in_plain, in_bank, in_scr, ro_hit;

  assign tl_ok    = (tl != '0) && (int'(tl) <= MAX_TL);
  assign in_plain = idx < IX_PLAIN_END;
  assign in_bank  = (idx >= IX_BANK0) && (idx < IX_BANK0 + IXW'(N_KINDS));
  assign in_scr   = (idx >= IX_SCR0) && (idx < IX_SCR0 + IXW'(N_SCR));
  assign ro_hit   = WRITE_SIDE && ((idx == IX_VERS) || (idx == IX_CTXW));

  always_comb begin
    dec.bank = in_bank;
    dec.scr  = in_scr;
    dec.sub  = idx[2:0];
    dec.bad  = en && !((in_plain && !ro_hit) || (in_bank && tl_ok) || in_scr);
  end

endmodule

// File: rtl/trap_ctl_array.sv
module trap_ctl_array #(
  parameter int DEPTH = 8,
  parameter int W = 64,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && (int'(widx) < DEPTH)) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = (int'(ridx) < DEPTH) ? mem[ridx] : '0;

endmodule

// File: rtl/trap_ctl_regfile.sv
module trap_ctl_regfile
  import trap_ctl_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int MAX_TL = 6,
  parameter int MAX_GL = 3,
  localparam int TL_W = $clog2(MAX_TL + 1),
  localparam int BIW = (MAX_TL > 1) ? $clog2(MAX_TL) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_en,
  input  logic [5:0]     rd_idx,
  output logic [63:0]    rd_data,
  input  logic           wr_en,
  input  logic [5:0]     wr_idx,
  input  logic [63:0]    wr_data,
  output logic           err_o
);

  logic [DW-1:0] pstate_q, tbase_q, winptr_q, fpst_q, hstate_q, strand_q;
  logic [DW-1:0] pctx_q, sctx_q, part_q, lsctl_q, glvl_q;
  logic [TL_W-1:0] tl_q;

  dec_t rdec, wdec;

  // named internal events
  logic wr_ok, wr_bad, rd_bad, bank_wr, scr_wr;
  logic [BIW-1:0] bank_sel;
  logic [DW-1:0] bank_rd [N_KINDS];
  logic [DW-1:0] scr_rd;

  trap_ctl_decode #(.WRITE_SIDE(1'b0), .MAX_TL(MAX_TL), .TL_W(TL_W)) u_rdec (
    .en(rd_en), .idx(rd_idx), .tl(tl_q), .dec(rdec));
  trap_ctl_decode #(.WRITE_SIDE(1'b1), .MAX_TL(MAX_TL), .TL_W(TL_W)) u_wdec (
    .en(wr_en), .idx(wr_idx), .tl(tl_q), .dec(wdec));

  assign rd_bad   = rdec.bad;
  assign wr_bad   = wdec.bad;
  assign wr_ok    = wr_en && !wdec.bad;
  assign bank_wr  = wr_ok && wdec.bank;
  assign scr_wr   = wr_ok && wdec.scr;
  assign bank_sel = BIW'(tl_q - 1'b1);

  // one copy set per trap-context kind
  for (genvar k = 0; k < N_KINDS; k++) begin : g_kind
    logic kind_we;
    assign kind_we = bank_wr && (wdec.sub == 3'(k));
    trap_ctl_array #(.DEPTH(MAX_TL), .W(DW)) u_copies (
      .clk(clk), .rst_n(rst_n), .we(kind_we), .widx(bank_sel),
      .wdata(wr_data), .ridx(bank_sel), .rdata(bank_rd[k]));
  end

  trap_ctl_array #(.DEPTH(N_SCR), .W(DW)) u_scratch (
    .clk(clk), .rst_n(rst_n), .we(scr_wr), .widx(wdec.sub),
    .wdata(wr_data), .ridx(rdec.sub), .rdata(scr_rd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pstate_q <= '0;
      tl_q     <= '0;
      tbase_q  <= '0;
      winptr_q <= '0;
      fpst_q   <= '0;
      hstate_q <= HSTATE_RST;
      strand_q <= STRAND_RST;
      pctx_q   <= '0;
      sctx_q   <= '0;
      part_q   <= '0;
      lsctl_q  <= '0;
      glvl_q   <= '0;
    end else if (wr_ok && !wdec.bank && !wdec.scr) begin
      case (wr_idx)
        IX_PSTATE: pstate_q <= filt_pstate(wr_data);
        IX_TLVL:   tl_q     <= wr_data[TL_W-1:0];
        IX_TBASE:  tbase_q  <= filt_tbase(wr_data);
        IX_WINPTR: winptr_q <= clamp_win(wr_data, NWIN);
        IX_FPST:   fpst_q   <= wr_data;
        IX_HSTATE: hstate_q <= wr_data;
        IX_STRAND: strand_q <= wr_data;
        IX_PCTX:   pctx_q   <= wr_data;
        IX_SCTX:   sctx_q   <= wr_data;
        IX_PART:   part_q   <= wr_data;
        IX_LSCTL:  lsctl_q  <= wr_data;
        IX_GLVL:   glvl_q   <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_o <= 1'b0;
    else        err_o <= rd_bad || wr_bad;
  end

  logic [DW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (rdec.bank) begin
      rd_val = bank_rd[rdec.sub];
    end else if (rdec.scr) begin
      rd_val = scr_rd;
    end else begin
      case (rd_idx)
        IX_PSTATE: rd_val = pstate_q;
        IX_TLVL:   rd_val = DW'(tl_q);
        IX_TBASE:  rd_val = tbase_q;
        IX_WINPTR: rd_val = winptr_q;
        IX_FPST:   rd_val = fpst_view(fpst_q);
        IX_HSTATE: rd_val = hstate_q;
        IX_STRAND: rd_val = strand_q;
        IX_VERS:   rd_val = vers_word(NWIN, MAX_TL, MAX_GL);
        IX_CTXW:   rd_val = pack_ctx(hstate_q, pstate_q, lsctl_q, part_q,
                                     3'(tl_q), pctx_q, sctx_q);
        IX_PCTX:   rd_val = pctx_q;
        IX_SCTX:   rd_val = sctx_q;
        IX_PART:   rd_val = part_q;
        IX_LSCTL:  rd_val = lsctl_q;
        IX_GLVL:   rd_val = glvl_q;
        default:   rd_val = '0;
      endcase
    end
  end

  assign rd_data = (rd_en && !rd_bad) ? rd_val : '0;

  // checks next to the logic they guard
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_bad || wr_bad) |=> err_o);  // R10
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_bad || wr_bad) |=> !err_o);  // R10
  AST_REFUSED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> ($stable(pstate_q) && $stable(tl_q) && $stable(tbase_q) && $stable(winptr_q)));  // R10
  AST_BANK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |-> (tl_q != '0 && int'(tl_q) <= MAX_TL));  // R9
  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    winptr_q <= DW'(NWIN));  // R4
  AST_PSTATE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wr_idx == IX_PSTATE) |=> ((pstate_q & ~PSTATE_KEEP) == '0));  // R2
  AST_TBASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wr_idx == IX_TBASE) |=> (tbase_q[63:15] == $past(wr_data[63:15])));  // R3

endmodule

// File: tb/test_trap_ctl_regfile.sv
`timescale 1ns/1ps
module test_trap_ctl_regfile;

  localparam int NWIN = 8, MAX_TL = 6, MAX_GL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [5:0] rd_idx = '0, wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic err_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trap_ctl_regfile #(.NWIN(NWIN), .MAX_TL(MAX_TL), .MAX_GL(MAX_GL)) i_trap_ctl_regfile (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .err_o(err_o));

  // bench model
  logic [63:0] m_reg [16];
  logic [63:0] m_bank [5][8];
  logic [63:0] m_scr [8];
  logic [2:0]  m_tl;

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_reg[i] = '0;
    for (int k = 0; k < 5; k++) for (int l = 0; l < 8; l++) m_bank[k][l] = '0;
    for (int i = 0; i < 8; i++) m_scr[i] = '0;
    m_reg[5] = 64'd2048;
    m_reg[6] = 64'd327680;
    m_tl = 3'd0;
  endtask

  function automatic bit lvl_ok();
    return m_tl >= 3'd1 && m_tl <= 3'(MAX_TL);
  endfunction

  function automatic bit legal(bit is_wr, logic [5:0] ix);
    if (ix <= 6'd13) return !(is_wr && (ix == 6'd7 || ix == 6'd8));
    if (ix >= 6'd16 && ix <= 6'd20) return lvl_ok();
    if (ix >= 6'd24 && ix <= 6'd31) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [63:0] keep_pstate(logic [63:0] d);
    logic [63:0] r = '0;
    int keep [9] = '{1, 2, 3, 4, 6, 7, 8, 9, 12};
    foreach (keep[j]) r[keep[j]] = d[keep[j]];
    return r;
  endfunction

  function automatic logic [63:0] exp_read(logic [5:0] ix);
    logic [63:0] r;
    if (!legal(1'b0, ix)) return '0;
    if (ix >= 6'd16 && ix <= 6'd20) return m_bank[ix - 6'd16][m_tl];
    if (ix >= 6'd24) return m_scr[ix - 6'd24];
    case (ix)
      6'd1: return {61'd0, m_tl};
      6'd4: return {m_reg[4][63:2], 2'b11};
      6'd7: return 64'd3 * 65536 + 64'd6 * 256 + 64'd8;
      6'd8: begin
        r = '0;
        r = r | {63'd0, m_reg[5][2]};
        r = r | ({63'd0, m_reg[5][5]} << 1);
        r = r | ({62'd0, m_reg[0][3:2]} << 2);
        r = r | ({62'd0, m_reg[12][3:2]} << 4);
        r = r | ({56'd0, m_reg[11][7:0]} << 8);
        r = r | ({61'd0, m_tl} << 16);
        r = r | ({48'd0, m_reg[9][15:0]} << 32);
        r = r | ({48'd0, m_reg[10][15:0]} << 48);
        return r;
      end
      default: return m_reg[ix];
    endcase
  endfunction

  task automatic model_write(logic [5:0] ix, logic [63:0] d);
    if (ix >= 6'd16 && ix <= 6'd20) m_bank[ix - 6'd16][m_tl] = d;
    else if (ix >= 6'd24) m_scr[ix - 6'd24] = d;
    else case (ix)
      6'd0: m_reg[0] = keep_pstate(d);
      6'd1: m_tl = d[2:0];
      6'd2: m_reg[2] = d & ~64'h7FFF;
      6'd3: m_reg[3] = (d > 64'd8) ? 64'd7 : d;
      default: m_reg[ix] = d;
    endcase
  endtask

  function automatic string tag_of(logic [5:0] ix);
    if (ix >= 6'd16 && ix <= 6'd20) return lvl_ok() ? "R8" : "R9";
    if (ix >= 6'd24 && ix <= 6'd31) return "R11";
    case (ix)
      6'd0: return "R2"; 6'd2: return "R3"; 6'd3: return "R4"; 6'd4: return "R5";
      6'd7: return "R6"; 6'd8: return "R7";
      default: return (ix <= 6'd13) ? "R12" : "R10";
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // one access: read sampled before the write lands, error sampled a cycle later
  task automatic op(bit we, logic [5:0] wi, logic [63:0] wd, bit re, logic [5:0] ri, string tag);
    logic [63:0] exp_d;
    bit exp_e;
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_data = wd; rd_en = re; rd_idx = ri;
    #1;
    exp_d = re ? exp_read(ri) : 64'd0;
    exp_e = (re && !legal(1'b0, ri)) || (we && !legal(1'b1, wi));
    if (re) check(rd_data === exp_d, tag, "read data", rd_data, exp_d);
    @(posedge clk);
    if (we && legal(1'b1, wi)) model_write(wi, wd);
    @(negedge clk);
    #1;
    check(err_o === exp_e, tag, "error flag", {63'd0, err_o}, {63'd0, exp_e});
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(logic [5:0] ix, logic [63:0] d, string tag);
    op(1'b1, ix, d, 1'b0, 6'd0, tag);
  endtask
  task automatic rd(logic [5:0] ix, string tag);
    op(1'b0, 6'd0, 64'd0, 1'b1, ix, tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h2C3A_11F5));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    for (int i = 0; i < 14; i++) rd(6'(i), "R1");
    for (int i = 24; i < 32; i++) rd(6'(i), "R1");
    check(err_o === 1'b0, "R1", "error after reset", {63'd0, err_o}, 64'd0);

    // R2 state mask
    wr(6'd0, '1, "R2"); rd(6'd0, "R2");
    wr(6'd0, 64'h0000_0000_0000_0C21, "R2"); rd(6'd0, "R2");
    // R3 base alignment
    wr(6'd2, '1, "R3"); rd(6'd2, "R3");
    // R4 window clamp: above, at and below the window count
    wr(6'd3, 64'd9, "R4"); rd(6'd3, "R4");
    wr(6'd3, 64'd8, "R4"); rd(6'd3, "R4");
    wr(6'd3, 64'd3, "R4"); rd(6'd3, "R4");
    wr(6'd3, 64'hFFFF_0000_0000_0001, "R4"); rd(6'd3, "R4");
    // R5 forced low bits
    wr(6'd4, 64'd0, "R5"); rd(6'd4, "R5");
    wr(6'd4, 64'hF0, "R5"); rd(6'd4, "R5");
    // R6 version read-only
    wr(6'd7, '1, "R6"); rd(6'd7, "R6");
    // R7 context packing
    wr(6'd5, 64'h24, "R7"); wr(6'd0, 64'hC, "R7"); wr(6'd12, 64'h8, "R7");
    wr(6'd11, 64'h1A5, "R7"); wr(6'd9, 64'h9_BEEF, "R7"); wr(6'd10, 64'h7_C0DE, "R7");
    wr(6'd1, 64'd5, "R7"); rd(6'd8, "R7");
    wr(6'd8, 64'd1, "R7");
    // R8 per-level copies
    wr(6'd1, 64'd1, "R8"); wr(6'd16, 64'hAAAA, "R8"); wr(6'd19, 64'h11, "R8");
    wr(6'd1, 64'd2, "R8"); wr(6'd16, 64'hBBBB, "R8"); rd(6'd16, "R8"); rd(6'd19, "R8");
    wr(6'd1, 64'd1, "R8"); rd(6'd16, "R8"); rd(6'd19, "R8");
    wr(6'd1, 64'd6, "R8"); wr(6'd20, 64'h66, "R8"); rd(6'd20, "R8");
    // R9 level 0 and level 7 refused
    wr(6'd1, 64'd0, "R9"); wr(6'd16, 64'hDEAD, "R9"); rd(6'd16, "R9");
    wr(6'd1, 64'd7, "R9"); wr(6'd17, 64'hDEAD, "R9"); rd(6'd17, "R9");
    wr(6'd1, 64'd1, "R9"); rd(6'd16, "R9"); rd(6'd17, "R9");
    // R10 unimplemented indices
    wr(6'd63, 64'h5, "R10"); rd(6'd63, "R10"); rd(6'd14, "R10"); rd(6'd21, "R10");
    op(1'b1, 6'd40, 64'h1, 1'b1, 6'd0, "R10"); rd(6'd0, "R10");
    // R11 scratchpads
    for (int i = 0; i < 8; i++) wr(6'(24 + i), 64'h1000 + 64'(i) * 64'h111, "R11");
    for (int i = 0; i < 8; i++) rd(6'(24 + i), "R11");
    // R12 same-cycle read and write
    op(1'b1, 6'd13, 64'h77, 1'b1, 6'd13, "R12"); rd(6'd13, "R12");
    op(1'b1, 6'd27, 64'h99, 1'b1, 6'd27, "R12"); rd(6'd27, "R12");

    // constrained random traffic
    for (int n = 0; n < 600; n++) begin
      logic [5:0] wi, ri;
      logic [63:0] wd;
      bit we, re;
      case ($urandom % 4)
        0: wi = 6'($urandom % 14);
        1: wi = 6'(16 + $urandom % 5);
        2: wi = 6'(24 + $urandom % 8);
        default: wi = ($urandom % 3 == 0) ? 6'd1 : 6'($urandom % 64);
      endcase
      case ($urandom % 3)
        0: ri = 6'($urandom % 14);
        1: ri = 6'(16 + $urandom % 5);
        default: ri = 6'($urandom % 64);
      endcase
      wd = {$urandom, $urandom};
      if (wi == 6'd1) wd = 64'($urandom % 8);
      if (wi == 6'd3 && ($urandom % 2 == 1)) wd = 64'($urandom % 12);
      we = ($urandom % 4) != 0;
      re = ($urandom % 4) != 0;
      op(we, wi, wd, re, ri, tag_of(re ? ri : wi));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule